// File: doc/BRIEF.md
# Three-Mode Down-Counting Timer with Two Capture/Reload Registers

This block is a 16-bit down counter with two 16-bit companion registers, A and B, run by one of three operations chosen by a 3-bit mode code. As a pulse generator it reloads from A and B in turn, and it can invert an output pin on every reload. As an event counter it counts rising edges on pin A. As a capture unit it counts a free-running tick and copies the count into A or B when the chosen edge arrives on pin A or pin B.

Software reaches the block through a small register port: a write strobe with address and data, and a separate read address whose data comes back registered one clock later. Both pins pass through a two-flop synchronizer before edges are found. Each of the two interrupt channels has a pending flag and an enable, and the interrupt line is raised only while both are set.

Top module: `mtmr_top`

## Requirements
- R1: Register addresses are 0 counter, 1 register A, 2 register B, 3 control. Control bits are [0] C0, [3:1] mode {C3,C2,C1}, [4] pending A, [5] enable A, [6] pending B, [7] enable B, and the upper bits read 0. Read data appears one clock after rd_addr. After reset every register reads 0, and pwm_out, irq_a and irq_b are 0.
- R2: In modes 100 and 101 the counter decrements once per clock that has tick high, but only while C0 is 1. With C0 at 0 or tick low it holds its value.
- R3: In modes 100 and 101 a decrement step taken at 0 reloads the counter instead. Reloads alternate between A and B, the first one after the mode is entered running uses A, a load from A sets pending A, and a load from B sets pending B.
- R4: In mode 101 pwm_out inverts on every reload. In mode 100 it keeps its level.
- R5: In modes 000 and 001, while C0 is 1, the counter decrements once per synchronized rising edge of pin_a and ignores tick. A step taken at 0 wraps it to all ones and sets pending A. A rising edge on pin_b sets pending B.
- R6: In capture modes 010, 110, 011 and 111 the counter decrements on every tick whatever C0 holds. The selected pin A edge copies the counter into A and sets pending A. The selected pin B edge copies the counter into B and sets pending B. Pin A captures on a rising edge when C1 is 0 and on a falling edge when C1 is 1. Pin B captures on a rising edge when C3 is 0 and on a falling edge when C3 is 1.
- R7: In capture modes a counter step at 0 wraps to all ones and sets both C0 (as an underflow flag) and pending A.
- R8: A pending flag, and C0 in capture modes, is cleared by writing 0 to its bit. Writing 1 leaves it unchanged. If a hardware set and a software clear fall in the same cycle, the flag ends up set.
- R9: irq_a equals pending A AND enable A one clock later, and irq_b does the same for channel B.
- R10: In a capture mode an edge of the polarity that was not selected changes neither A nor B nor their pending flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable for pulse and capture modes |
| pin_a | input | 1 | Asynchronous input pin A |
| pin_b | input | 1 | Asynchronous input pin B |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Registered read data |
| pwm_out | output | 1 | Pulse output pin |
| irq_a | output | 1 | Interrupt request, channel A |
| irq_b | output | 1 | Interrupt request, channel B |

## Verification
The main collision is a software write that clears pending B landing on the same clock edge at which a synchronized pin B capture edge sets it. The bench raises pin_b exactly two clocks before the control write strobe, so the edge pulse leaving the synchronizer coincides with the write, and it then expects pending B to read back as 1. A control case that clears the flag with no edge present shows the clear itself works. Capture values are judged with tick held low, so the copied count is the value last written.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADR_CNT  = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_REGA = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_REGB = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd3;

  // control register bit positions
  localparam int unsigned CB_C0   = 0;
  localparam int unsigned CB_MLO  = 1;
  localparam int unsigned CB_MHI  = 3;
  localparam int unsigned CB_PNDA = 4;
  localparam int unsigned CB_ENA  = 5;
  localparam int unsigned CB_PNDB = 6;
  localparam int unsigned CB_ENB  = 7;
  localparam int unsigned CTRL_W  = 8;

  typedef struct packed {
    logic is_pwm;
    logic do_toggle;
    logic is_evt;
    logic is_cap;
    logic a_on_rise;
    logic b_on_rise;
  } mode_dec_t;
endpackage

// File: rtl/mtmr_edge_sync.sv
module mtmr_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], pin};
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/mtmr_mode_dec.sv
module mtmr_mode_dec
  import mtmr_pkg::*;
(
  input  logic [2:0] mode,
  output mode_dec_t  dec
);
  // mode = {C3,C2,C1}
  always_comb begin
    dec.is_pwm    = (mode[2:1] == 2'b10);
    dec.do_toggle = (mode == 3'b101);
    dec.is_evt    = (mode[2:1] == 2'b00);
    dec.is_cap    = mode[1];
    dec.a_on_rise = ~mode[0];
    dec.b_on_rise = ~mode[2];
  end
endmodule

// File: rtl/mtmr_counter.sv
module mtmr_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         is_pwm,
  input  logic         do_toggle,
  input  logic         run,
  input  logic         sw_load,
  input  logic [W-1:0] sw_val,
  input  logic [W-1:0] reg_a,
  input  logic [W-1:0] reg_b,
  output logic [W-1:0] cnt,
  output logic         rld_a,
  output logic         rld_b,
  output logic         wrap,
  output logic         pwm_out
);
  logic sel_q;
  logic hit;

  assign hit   = step && (cnt == '0);
  assign rld_a = hit && is_pwm && !sel_q;
  assign rld_b = hit && is_pwm && sel_q;
  assign wrap  = hit && !is_pwm;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      sel_q   <= 1'b0;
      pwm_out <= 1'b0;
    end else begin
      if (sw_load)    cnt <= sw_val;
      else if (rld_a) cnt <= reg_a;
      else if (rld_b) cnt <= reg_b;
      else if (step)  cnt <= cnt - 1'b1;

      if (!is_pwm || !run)    sel_q <= 1'b0;
      else if (rld_a || rld_b) sel_q <= ~sel_q;

      if ((rld_a || rld_b) && do_toggle) pwm_out <= ~pwm_out;
    end
  end

  a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
    (is_pwm && !run && !sw_load) |=> $stable(cnt));
  a_r3_alternate_after_a: assert property (@(posedge clk) disable iff (rst)
    (rld_a && run) |=> sel_q);
  a_r4_no_toggle_mode: assert property (@(posedge clk) disable iff (rst)
    (!do_toggle) |=> $stable(pwm_out));
endmodule

// File: rtl/mtmr_top.sv
module mtmr_top
  import mtmr_pkg::*;
#(
  parameter int unsigned W         = 16,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              pin_a,
  input  logic              pin_b,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [W-1:0]      rd_data,
  output logic              pwm_out,
  output logic              irq_a,
  output logic              irq_b
);
  localparam int unsigned NPIN = 2;

  logic [NPIN-1:0] pins, rise, fall;
  assign pins = {pin_b, pin_a};

  for (genvar g = 0; g < NPIN; g++) begin : g_sync
    mtmr_edge_sync #(.STAGES(SYNC_STGS)) u_sync (
      .clk(clk), .rst(rst), .pin(pins[g]), .rise(rise[g]), .fall(fall[g]));
  end

  logic [2:0] mode_q;
  logic       c0_q, pnda_q, ena_q, pndb_q, enb_q;
  logic [W-1:0] ra_q, rb_q, cnt;
  mode_dec_t  dec;

  mtmr_mode_dec u_dec (.mode(mode_q), .dec(dec));

  logic wr_cnt, wr_ra, wr_rb, wr_ctl;
  assign wr_cnt = wr_en && (wr_addr == ADR_CNT);
  assign wr_ra  = wr_en && (wr_addr == ADR_REGA);
  assign wr_rb  = wr_en && (wr_addr == ADR_REGB);
  assign wr_ctl = wr_en && (wr_addr == ADR_CTRL);

  logic step, rld_a, rld_b, wrap, cap_a, cap_b, set_a, set_b, set_c0;

  assign step = (dec.is_pwm && c0_q && tick)
              | (dec.is_evt && c0_q && rise[0])
              | (dec.is_cap && tick);

  mtmr_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .step(step), .is_pwm(dec.is_pwm),
    .do_toggle(dec.do_toggle), .run(c0_q), .sw_load(wr_cnt),
    .sw_val(wr_data), .reg_a(ra_q), .reg_b(rb_q), .cnt(cnt),
    .rld_a(rld_a), .rld_b(rld_b), .wrap(wrap), .pwm_out(pwm_out));

  assign cap_a  = dec.is_cap && (dec.a_on_rise ? rise[0] : fall[0]);
  assign cap_b  = dec.is_cap && (dec.b_on_rise ? rise[1] : fall[1]);
  assign set_a  = rld_a | wrap | cap_a;
  assign set_b  = rld_b | (dec.is_evt && rise[1]) | cap_b;
  assign set_c0 = wrap && dec.is_cap;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      c0_q   <= 1'b0;
      pnda_q <= 1'b0;
      ena_q  <= 1'b0;
      pndb_q <= 1'b0;
      enb_q  <= 1'b0;
      ra_q   <= '0;
      rb_q   <= '0;
      irq_a  <= 1'b0;
      irq_b  <= 1'b0;
    end else begin
      if (wr_ctl) begin
        mode_q <= wr_data[CB_MHI:CB_MLO];
        ena_q  <= wr_data[CB_ENA];
        enb_q  <= wr_data[CB_ENB];
      end
      pnda_q <= set_a | (pnda_q & (!wr_ctl | wr_data[CB_PNDA]));
      pndb_q <= set_b | (pndb_q & (!wr_ctl | wr_data[CB_PNDB]));
      if (set_c0)                    c0_q <= 1'b1;
      else if (wr_ctl && dec.is_cap) c0_q <= c0_q & wr_data[CB_C0];
      else if (wr_ctl)               c0_q <= wr_data[CB_C0];

      if (cap_a)      ra_q <= cnt;
      else if (wr_ra) ra_q <= wr_data;
      if (cap_b)      rb_q <= cnt;
      else if (wr_rb) rb_q <= wr_data;

      irq_a <= pnda_q & ena_q;
      irq_b <= pndb_q & enb_q;
    end
  end

  logic [CTRL_W-1:0] ctrl_view;
  assign ctrl_view = {enb_q, pndb_q, ena_q, pnda_q, mode_q, c0_q};

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (rd_addr)
        ADR_CNT:  rd_data <= cnt;
        ADR_REGA: rd_data <= ra_q;
        ADR_REGB: rd_data <= rb_q;
        default:  rd_data <= {{(W-CTRL_W){1'b0}}, ctrl_view};
      endcase
    end
  end

  a_r8_set_wins_b: assert property (@(posedge clk) disable iff (rst)
    set_b |=> pndb_q);
  a_r8_set_wins_a: assert property (@(posedge clk) disable iff (rst)
    set_a |=> pnda_q);
  a_r9_irq_a_follows: assert property (@(posedge clk) disable iff (rst)
    (pnda_q && ena_q) |=> irq_a);
  a_r7_underflow_flag: assert property (@(posedge clk) disable iff (rst)
    (wrap && dec.is_cap) |=> c0_q);
  a_r6_capture_copies: assert property (@(posedge clk) disable iff (rst)
    cap_a |=> (ra_q == $past(cnt)));
  a_r10_no_stray_capture: assert property (@(posedge clk) disable iff (rst)
    (!cap_b && !wr_rb) |=> $stable(rb_q));
endmodule

// File: tb/tb_mtmr_top.sv
`timescale 1ns/1ps
module tb_mtmr_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        pin_a = 1'b0;
  logic        pin_b = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        pwm_out, irq_a, irq_b;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mtmr_top dut (.*);

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk); rd_addr = a;
    @(negedge clk); v = rd_data;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    for (int i = 0; i < 4; i++) begin
      rd(2'(i), v); chk("R1 reset reg", v, 16'h0);
    end
    chk("R1 reset pwm", {15'b0, pwm_out}, 16'h0);
    chk("R1 reset irq", {14'b0, irq_b, irq_a}, 16'h0);
  endtask

  task automatic t_pwm();
    logic [15:0] v;
    wr(1, 16'd2); wr(2, 16'd3); wr(0, 16'd1);
    wr(3, 16'h002B);
    ticks(2);
    rd(0, v); chk("R3 reload from A", v, 16'd2);
    rd(3, v); chk("R3 pending A", v, 16'h003B);
    chk("R4 toggle high", {15'b0, pwm_out}, 16'h1);
    chk("R9 irq_a raised", {15'b0, irq_a}, 16'h1);
    ticks(3);
    rd(0, v); chk("R3 reload from B", v, 16'd3);
    rd(3, v); chk("R3 pending B", v, 16'h007B);
    chk("R4 toggle low", {15'b0, pwm_out}, 16'h0);
    chk("R9 irq_b masked", {15'b0, irq_b}, 16'h0);
    // stopped: C0=0
    wr(3, 16'h000A); wr(0, 16'd7); ticks(3);
    rd(0, v); chk("R2 hold when stopped", v, 16'd7);
    wr(3, 16'h000B); repeat (3) @(negedge clk);
    rd(0, v); chk("R2 hold without tick", v, 16'd7);
    ticks(2);
    rd(0, v); chk("R2 count on tick", v, 16'd5);
    // no-toggle mode
    wr(3, 16'h0000); wr(1, 16'd4); wr(0, 16'd0); wr(3, 16'h0009);
    ticks(1);
    rd(0, v); chk("R3 mode 100 reload A", v, 16'd4);
    chk("R4 no toggle in 100", {15'b0, pwm_out}, 16'h0);
    rd(3, v); chk("R3 mode 100 pending A", v, 16'h0019);
  endtask

  task automatic t_event();
    logic [15:0] v;
    wr(3, 16'h0000); wr(0, 16'd1); wr(3, 16'h0001);
    ticks(5);
    rd(0, v); chk("R5 tick ignored", v, 16'd1);
    pin_a = 1'b1; settle(); pin_a = 1'b0; settle();
    rd(0, v); chk("R5 edge decrements", v, 16'd0);
    pin_a = 1'b1; settle(); pin_a = 1'b0; settle();
    rd(0, v); chk("R5 wrap to ones", v, 16'hFFFF);
    rd(3, v); chk("R5 pending A on wrap", v, 16'h0011);
    pin_b = 1'b1; settle(); pin_b = 1'b0; settle();
    rd(3, v); chk("R5 pending B on pin_b", v, 16'h0051);
    wr(3, 16'h00D1); settle();
    chk("R9 irq_b raised", {15'b0, irq_b}, 16'h1);
    chk("R9 irq_a masked", {15'b0, irq_a}, 16'h0);
    rd(3, v); chk("R8 write 1 keeps", v, 16'h00D1);
  endtask

  task automatic t_capture();
    logic [15:0] v;
    wr(3, 16'h0000); wr(0, 16'h1234); wr(3, 16'h0004);
    pin_a = 1'b1; settle();
    rd(1, v); chk("R6 A rise capture", v, 16'h1234);
    rd(3, v); chk("R6 pending A", v, 16'h0014);
    wr(0, 16'h5678);
    pin_b = 1'b1; settle();
    rd(2, v); chk("R6 B rise capture", v, 16'h5678);
    rd(3, v); chk("R6 pending B", v, 16'h0054);
    wr(3, 16'h0004);
    rd(3, v); chk("R8 write 0 clears", v, 16'h0004);
    pin_a = 1'b0; settle();
    rd(1, v); chk("R10 falling A ignored", v, 16'h1234);
    rd(3, v); chk("R10 no pending", v, 16'h0004);
    wr(3, 16'h000E); wr(0, 16'h0ABC);
    pin_b = 1'b0; settle();
    rd(2, v); chk("R6 B fall capture in 111", v, 16'h0ABC);
    pin_a = 1'b1; settle();
    rd(1, v); chk("R10 rising A ignored in 111", v, 16'h1234);
    pin_a = 1'b0; settle();
    rd(1, v); chk("R6 A fall capture in 111", v, 16'h0ABC);
  endtask

  task automatic t_underflow();
    logic [15:0] v;
    wr(3, 16'h0004); wr(0, 16'd1);
    ticks(1);
    rd(0, v); chk("R6 cap counts on tick", v, 16'd0);
    rd(3, v); chk("R7 no flag yet", v, 16'h0004);
    ticks(1);
    rd(0, v); chk("R7 wrap", v, 16'hFFFF);
    rd(3, v); chk("R7 C0 and pending A", v, 16'h0015);
    wr(3, 16'h0055);
    rd(3, v); chk("R8 write 1 no set", v, 16'h0015);
    wr(3, 16'h0004);
    rd(3, v); chk("R8 C0 cleared", v, 16'h0004);
  endtask

  task automatic t_collision();
    logic [15:0] v;
    // mode 010, pin_b low: rising edge captures
    @(negedge clk); pin_b = 1'b1;
    @(negedge clk);
    wr(3, 16'h0004);
    rd(3, v); chk("R8 set beats clear", v, 16'h0044);
    wr(3, 16'h0004);
    rd(3, v); chk("R8 clear alone", v, 16'h0004);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_pwm();
    t_event();
    t_capture();
    t_underflow();
    t_collision();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule